// File: doc/BRIEF.md
# Load data rotate and extend unit

This unit sits between the data read port of a processor's load path and the register file write port. Each request carries the raw 32-bit word returned by memory, the two low bits of the byte address, and an access kind. One clock later the unit presents the value to be written to the destination register. A word read from an address that is not word aligned is not faulted: the word is rotated right so that the addressed byte lands in the low lane. Byte and halfword reads pick their lane from the address and are then zero- or sign-extended.

The kind code also marks a word load whose destination is the program counter. For that kind the unit raises a jump flag alongside the result. A mode input, set on cores that keep no state in bit 0 of a branch target, forces bit 0 of that target to zero. An atomic swap's read half uses the plain word kind, since it follows the same rotate rule.

Top module: `ldfmt_top`

## Requirements
- R1: While reset is held and after its release, before any request, `res_vld`, `res_jump` and `res_data` are all zero.
- R2: A request with `req_vld` high gives a `res_vld` pulse exactly one cycle later; a cycle without a request gives `res_vld` low one cycle later.
- R3: Kind 0 (word): the result is `rd_data` rotated right by 8 × `req_addr` bits.
- R4: Kind 1 (unsigned byte): the result is byte lane `req_addr` of `rd_data` (lane 0 is bits 7:0), zero-extended.
- R5: Kind 2 (unsigned halfword): the result is halfword lane `req_addr[1]` of `rd_data`, zero-extended; `req_addr[0]` has no effect.
- R6: Kind 3 (signed byte): byte lane `req_addr`, with its bit 7 copied into bits 31:8.
- R7: Kind 4 (signed halfword): halfword lane `req_addr[1]`, with its bit 15 copied into bits 31:16; `req_addr[0]` has no effect.
- R8: Kind 5 (word to program counter): the result is rotated as for kind 0 and `res_jump` is high with the `res_vld` pulse; every other kind gives `res_jump` low.
- R9: With `pc_bit0_clr` high, a kind 5 result has bit 0 cleared; `pc_bit0_clr` has no effect on any other kind or when low.
- R10: In a cycle after no request, `res_data` keeps the previous result and `res_jump` is low, whatever the other inputs do.
- R11: Kinds 6 and 7 are treated as kind 0: rotated word, no jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req_vld | input | 1 | A load result is presented this cycle |
| req_kind | input | 3 | Access kind code (see R3 to R11) |
| req_addr | input | 2 | Low byte-address bits of the access |
| rd_data | input | 32 | Raw word read from memory |
| pc_bit0_clr | input | 1 | Clear bit 0 of program-counter targets |
| res_vld | output | 1 | One-cycle pulse: result valid |
| res_data | output | 32 | Value for the destination register |
| res_jump | output | 1 | Result is a branch target |

## Verification
Every kind code, every address offset and both settings of the bit-0 mode are swept over data words chosen so that sign bits sit in different lanes, so a lane picked from the wrong address bits, a rotation in the wrong direction, or an extension taken from the wrong bit shows up as a wrong upper or lower byte. Halfword kinds at odd offsets catch a design that lets address bit 0 shift the lane. The bit-0 mode applied to non-branch kinds catches a mask that is not gated by the kind, and the reserved codes catch a decoder that drops to zero or raises a jump. Idle cycles with changing inputs between requests catch an output register that loads without a request or a jump flag that lingers.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  typedef enum logic [2:0] {
    LK_WORD    = 3'd0,
    LK_UBYTE   = 3'd1,
    LK_UHALF   = 3'd2,
    LK_SBYTE   = 3'd3,
    LK_SHALF   = 3'd4,
    LK_WORD_PC = 3'd5
  } ld_kind_e;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned HALF_W = 16;

endpackage

// File: rtl/ldfmt_rotr.sv
module ldfmt_rotr #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / ldfmt_pkg::LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DATA_W-1:0] dout
);
  localparam int LW = ldfmt_pkg::LANE_W;

  // Output lane i takes input lane (i + ofs) mod LANES: a right rotate by LW*ofs.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFS_W-1:0] src;
    assign src = OFS_W'(i) + ofs;
    assign dout[i*LW +: LW] = din[src*LW +: LW];
  end

endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [2:0]        kind,
  output logic [DATA_W-1:0] dout
);
  import ldfmt_pkg::*;

  logic [LANE_W-1:0] lo_b;
  logic [HALF_W-1:0] lo_h;

  assign lo_b = din[LANE_W-1:0];
  assign lo_h = din[HALF_W-1:0];

  always_comb begin
    case (kind)
      LK_UBYTE: dout = {{(DATA_W-LANE_W){1'b0}}, lo_b};
      LK_SBYTE: dout = {{(DATA_W-LANE_W){lo_b[LANE_W-1]}}, lo_b};
      LK_UHALF: dout = {{(DATA_W-HALF_W){1'b0}}, lo_h};
      LK_SHALF: dout = {{(DATA_W-HALF_W){lo_h[HALF_W-1]}}, lo_h};
      default:  dout = din;
    endcase
  end

endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top #(
  parameter int DATA_W = 32,
  localparam int OFS_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        req_kind,
  input  logic [OFS_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              pc_bit0_clr,
  output logic              res_vld,
  output logic [DATA_W-1:0] res_data,
  output logic              res_jump
);
  import ldfmt_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  // Kind decode.
  logic is_half, is_pc;
  assign is_half = (req_kind == LK_UHALF) || (req_kind == LK_SHALF);
  assign is_pc   = (req_kind == LK_WORD_PC);

  // Halfwords rotate by the even offset so the selected half lands low.
  logic [OFS_W-1:0] eff_ofs;
  assign eff_ofs = is_half ? {req_addr[OFS_W-1:1], 1'b0} : req_addr;

  logic [DATA_W-1:0] rot_data, ext_data, fmt_data;

  ldfmt_rotr #(.DATA_W(DATA_W)) u_rotr (
    .din  (rd_data),
    .ofs  (eff_ofs),
    .dout (rot_data)
  );

  ldfmt_extend #(.DATA_W(DATA_W)) u_ext (
    .din  (rot_data),
    .kind (req_kind),
    .dout (ext_data)
  );

  always_comb begin
    fmt_data = ext_data;
    if (is_pc && pc_bit0_clr) fmt_data[0] = 1'b0;
  end

  // Next state.
  logic              data_en;
  logic              vld_d, jump_d;
  logic [DATA_W-1:0] data_d;
  logic              vld_q, jump_q;
  logic [DATA_W-1:0] data_q;

  assign data_en = req_vld;

  always_comb begin
    vld_d  = req_vld;
    jump_d = req_vld && is_pc;
    data_d = data_en ? fmt_data : data_q;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      jump_q <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      jump_q <= jump_d;
      data_q <= data_d;
    end
  end

  assign res_vld  = vld_q;
  assign res_jump = jump_q;
  assign res_data = data_q;

endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              req_vld,
  input logic [2:0]        req_kind,
  input logic              pc_bit0_clr,
  input logic              res_vld,
  input logic [DATA_W-1:0] res_data,
  input logic              res_jump
);

  assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |-> (res_vld == $past(req_vld)));

  assert_jump_has_vld_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    res_jump |-> res_vld);

  assert_pc_bit0_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_vld) && $past(req_kind) == 3'd5 && $past(pc_bit0_clr))
      |-> (res_data[0] == 1'b0));

  assert_sbyte_ext_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_vld) && $past(req_kind) == 3'd3)
      |-> ((&res_data[DATA_W-1:7]) || !(|res_data[DATA_W-1:7])));

  assert_shalf_ext_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_vld) && $past(req_kind) == 3'd4)
      |-> ((&res_data[DATA_W-1:15]) || !(|res_data[DATA_W-1:15])));

  assert_ubyte_zero_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_vld) && $past(req_kind) == 3'd1)
      |-> (res_data[DATA_W-1:8] == '0));

  assert_uhalf_zero_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_vld) && $past(req_kind) == 3'd2)
      |-> (res_data[DATA_W-1:16] == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(req_vld)) |-> ($stable(res_data) && !res_jump));

  assert_reserved_nojump_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_vld) && $past(req_kind) >= 3'd6) |-> !res_jump);

endmodule

bind ldfmt_top ldfmt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_int_n),
  .req_vld     (req_vld),
  .req_kind    (req_kind),
  .pc_bit0_clr (pc_bit0_clr),
  .res_vld     (res_vld),
  .res_data    (res_data),
  .res_jump    (res_jump)
);

// File: tb/ldfmt_top_bench.sv
`timescale 1ns/1ps
module ldfmt_top_bench;

  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic [2:0]  req_kind;
  logic [1:0]  req_addr;
  logic [31:0] rd_data;
  logic        pc_bit0_clr;
  logic        res_vld;
  logic [31:0] res_data;
  logic        res_jump;

  ldfmt_top u_ldfmt_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_kind    (req_kind),
    .req_addr    (req_addr),
    .rd_data     (rd_data),
    .pc_bit0_clr (pc_bit0_clr),
    .res_vld     (res_vld),
    .res_data    (res_data),
    .res_jump    (res_jump)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;

  logic        exp_vld  = 1'b0;
  logic [31:0] exp_data = '0;
  logic        exp_jump = 1'b0;
  string       exp_tag  = "R1";
  string       jmp_tag  = "R1";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model(logic [2:0] k, logic [1:0] a,
                                        logic [31:0] d, logic c);
    logic [63:0] dd;
    logic [31:0] w, h;
    dd = {d, d};
    w  = 32'(dd >> (8 * a));
    h  = 32'(dd >> (8 * (a & 2'd2)));
    case (k)
      3'd1:    return {24'd0, w[7:0]};
      3'd2:    return {16'd0, h[15:0]};
      3'd3:    return {{24{w[7]}}, w[7:0]};
      3'd4:    return {{16{h[15]}}, h[15:0]};
      3'd5:    return c ? (w & 32'hFFFF_FFFE) : w;
      default: return w;
    endcase
  endfunction

  task automatic check_out();
    chk(exp_vld ? "R2 valid" : "R2 idle", {31'd0, res_vld}, {31'd0, exp_vld});
    chk(exp_vld ? exp_tag : "R10 data hold", res_data, exp_data);
    chk(exp_vld ? jmp_tag : "R10 jump low", {31'd0, res_jump}, {31'd0, exp_jump});
  endtask

  task automatic step(bit v, logic [2:0] k, logic [1:0] a, logic [31:0] d, logic c);
    @(negedge clk);
    check_out();
    req_vld = v; req_kind = k; req_addr = a; rd_data = d; pc_bit0_clr = c;
    exp_vld = v;
    exp_jump = v && (k == 3'd5);
    if (v) begin
      exp_data = model(k, a, d, c);
      case (k)
        3'd0:    exp_tag = "R3 word";
        3'd1:    exp_tag = "R4 ubyte";
        3'd2:    exp_tag = "R5 uhalf";
        3'd3:    exp_tag = "R6 sbyte";
        3'd4:    exp_tag = "R7 shalf";
        3'd5:    exp_tag = c ? "R9 pc clr" : "R8 pc word";
        default: exp_tag = "R11 reserved";
      endcase
      jmp_tag = (k >= 3'd6) ? "R11 jump" : "R8 jump";
    end
  endtask

  initial begin
    logic [31:0] pats [8];
    logic [31:0] lcg;
    int          n;
    rst_n = 1'b0; req_vld = 1'b0; req_kind = '0; req_addr = '0;
    rd_data = '0; pc_bit0_clr = 1'b0;
    pats[0] = 32'h1122_3344;
    pats[1] = 32'h80FF_7F01;
    pats[2] = 32'h7F80_01FF;
    pats[3] = 32'hFFFF_FFFF;
    lcg = 32'h1234_5678;
    for (int i = 4; i < 8; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      pats[i] = lcg;
    end
    repeat (3) @(negedge clk);
    // R1: outputs zero while reset is held
    chk("R1 vld in reset",  {31'd0, res_vld},  32'd0);
    chk("R1 data in reset", res_data,           32'd0);
    chk("R1 jump in reset", {31'd0, res_jump}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: still zero after release, no request yet
    chk("R1 vld after release",  {31'd0, res_vld},  32'd0);
    chk("R1 data after release", res_data,           32'd0);
    n = 0;
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 8; k++)
        for (int a = 0; a < 4; a++)
          for (int c = 0; c < 2; c++) begin
            step(1'b1, 3'(k), 2'(a), pats[p], c[0]);
            n++;
            if (n % 3 == 0) begin
              lcg = lcg * 32'd1103515245 + 32'd12345;
              // R10: idle cycle with busy inputs, including a program-counter kind
              step(1'b0, 3'd5, lcg[1:0], ~lcg, lcg[31]);
            end
          end
    step(1'b0, 3'd0, 2'd0, 32'hDEAD_BEEF, 1'b1);
    step(1'b0, 3'd3, 2'd1, 32'h0, 1'b0);
    @(negedge clk);
    check_out();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule